// File: doc/BRIEF.md
# Downward Stack Pointer with Byte-Wide Register Access

This unit holds the stack pointer of a small processor. The pointer is 11 bits wide. Software reads and writes it as two byte registers. The low byte carries pointer bits 7:0. The high byte carries pointer bits 10:8 in its three lowest positions. The stack grows toward lower addresses, and after reset the pointer sits at the highest data-memory address.

The processor raises one of four command strobes:
- a one-byte push;
- a one-byte pop;
- a return-address push (a call or interrupt entry);
- a return-address pop (a return).

For every command the unit presents a memory address, a write/read indication and the updated pointer.

A push writes at the current pointer and then moves down. A pop moves up first and then reads at the new pointer. A return address takes two consecutive cycles, one byte per cycle. The low byte of the return address lives at the higher of its two locations.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer equals TOP_ADDR (default 0x7FF). The low register reads 0xFF and the high register reads 0x07.
- R2: A push presents mem_addr = SP with mem_valid=1, mem_wr=1 and mem_hi_byte=0. The pointer becomes SP-1 on the next clock.
- R3: A pop presents mem_addr = SP+1 with mem_valid=1, mem_wr=0 and mem_hi_byte=0. The pointer becomes SP+1 on the next clock.
- R4: A return-address push lasts two cycles.
  - First cycle: mem_addr = SP, mem_wr=1, mem_hi_byte=0 (low byte).
  - Second cycle: mem_addr = SP-1, mem_wr=1, mem_hi_byte=1 (high byte).
  - The pointer ends at SP-2.
- R5: A return-address pop lasts two cycles.
  - First cycle: mem_addr = SP+1, mem_wr=0, mem_hi_byte=1 (high byte).
  - Second cycle: mem_addr = SP+2, mem_wr=0, mem_hi_byte=0 (low byte).
  - The pointer ends at SP+2.
- R6: Command strobes raised during the second cycle of a return-address transfer are ignored.
- R7: The high register reads pointer bits 10:8 in bits 2:0 and zero in bits 7:3. Writes to its bits 7:3 have no effect. The low register reads pointer bits 7:0.
- R8: A software byte write in the same cycle as a command wins over the arithmetic update.
  - A low write loads bits 7:0 from sw_wdata and keeps the high bits.
  - A high write loads bits 10:8 from sw_wdata[2:0] and keeps the low byte.
  - Any write cancels a pending second cycle.
- R9: Pointer arithmetic wraps modulo 2048. A push at 0x000 leaves 0x7FF, and a pop at 0x7FF reads address 0x000.
- R10: With no command and no pending second cycle, mem_valid is 0. When several strobes are raised together, the priority is push, then pop, then return-address push, then return-address pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_push | input | 1 | Push one data byte |
| cmd_pop | input | 1 | Pop one data byte |
| cmd_call | input | 1 | Push a two-byte return address |
| cmd_ret | input | 1 | Pop a two-byte return address |
| sw_wr_lo | input | 1 | Software write strobe, low pointer byte |
| sw_wr_hi | input | 1 | Software write strobe, high pointer byte |
| sw_wdata | input | 8 | Software write data |
| sw_rdata_lo | output | 8 | Low pointer byte read value |
| sw_rdata_hi | output | 8 | High pointer byte read value |
| sp_q | output | 11 | Current pointer |
| mem_addr | output | 11 | Address presented to data memory |
| mem_valid | output | 1 | Memory access this cycle |
| mem_wr | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_hi_byte | output | 1 | Return-address byte selector: 1 = high byte |

## Verification
The hardest situations to reach are those that land on the second cycle of a return-address transfer. One is a software write arriving while the second byte is still pending. The other is a fresh command strobe arriving in that same cycle. The bench reaches them by driving a directed call or return, then a write or a conflicting strobe exactly one cycle later. It also loads pointer values 0x000 and 0x7FF through the byte registers, so that the wrap in both directions is exercised by single-byte and two-byte transfers. A pseudo-random phase then mixes all strobes and writes, and a behavioural model is compared against the design every cycle.

// File: rtl/stk_pkg.sv
// Shared types for the stack pointer unit.
// Assumes a single pointer step per cycle of magnitude one.
package stk_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_DN   = 2'd1,
        STEP_UP   = 2'd2
    } step_t;
endpackage

// File: rtl/stk_cmd_seq.sv
// Command sequencer: turns the four command strobes into one pointer step per
// cycle plus memory access qualifiers. Two-byte transfers take two cycles; the
// second is tracked by busy. Assumes the CPU holds off new commands while busy
// (any that arrive are dropped). A software write cancels a pending second cycle.
module stk_cmd_seq
    import stk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_push,
    input  logic  cmd_pop,
    input  logic  cmd_call,
    input  logic  cmd_ret,
    input  logic  sw_wr,
    output step_t step,
    output logic  mem_valid,
    output logic  mem_wr,
    output logic  mem_hi_byte,
    output logic  busy
);
    logic busy_q;
    logic kind_call_q;      // 1: second cycle of call, 0: of return
    logic start_call;
    logic start_ret;

    // Decode the current cycle's step with push > pop > call > return priority.
    always_comb begin
        step        = STEP_NONE;
        mem_valid   = 1'b0;
        mem_wr      = 1'b0;
        mem_hi_byte = 1'b0;
        start_call  = 1'b0;
        start_ret   = 1'b0;
        if (busy_q) begin
            mem_valid   = 1'b1;
            mem_wr      = kind_call_q;
            mem_hi_byte = kind_call_q;
            step        = kind_call_q ? STEP_DN : STEP_UP;
        end else if (cmd_push) begin
            mem_valid = 1'b1;
            mem_wr    = 1'b1;
            step      = STEP_DN;
        end else if (cmd_pop) begin
            mem_valid = 1'b1;
            step      = STEP_UP;
        end else if (cmd_call) begin
            mem_valid  = 1'b1;
            mem_wr     = 1'b1;
            step       = STEP_DN;
            start_call = 1'b1;
        end else if (cmd_ret) begin
            mem_valid   = 1'b1;
            mem_hi_byte = 1'b1;
            step        = STEP_UP;
            start_ret   = 1'b1;
        end
    end

    // Track the pending second cycle of a two-byte transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            kind_call_q <= 1'b0;
        end else begin
            busy_q <= !sw_wr && (start_call || start_ret);
            if (start_call || start_ret)
                kind_call_q <= start_call;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/stk_addr_gen.sv
// Address generator: from the current pointer and the step, forms the memory
// address (pointer for a downward step, pointer+1 for an upward step) and the
// next pointer. Arithmetic wraps at the pointer width.
module stk_addr_gen
    import stk_pkg::*;
#(
    parameter int PTR_W = 11
) (
    input  logic [PTR_W-1:0] sp,
    input  step_t            step,
    output logic [PTR_W-1:0] addr,
    output logic [PTR_W-1:0] sp_next
);
    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;

    // Both neighbours of the pointer, wrapping modulo 2**PTR_W.
    assign sp_inc = sp + PTR_W'(1);
    assign sp_dec = sp - PTR_W'(1);

    // Select address and next pointer for the requested step.
    always_comb begin
        unique case (step)
            STEP_DN: begin addr = sp;     sp_next = sp_dec; end
            STEP_UP: begin addr = sp_inc; sp_next = sp_inc; end
            default: begin addr = sp;     sp_next = sp;     end
        endcase
    end
endmodule

// File: rtl/stk_ptr_reg.sv
// Pointer register with byte-wide software access. Software writes take
// priority over the arithmetic update. Assumes 9 <= PTR_W <= 16; upper bits of
// the high byte read as zero and ignore writes.
module stk_ptr_reg
    import stk_pkg::*;
#(
    parameter int PTR_W    = 11,
    parameter int TOP_ADDR = 11'h7FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    input  step_t            step,
    input  logic [PTR_W-1:0] sp_next,
    output logic [PTR_W-1:0] sp,
    output logic [7:0]       rd_lo,
    output logic [7:0]       rd_hi
);
    localparam int HI_W = PTR_W - 8;

    logic [PTR_W-1:0] sp_q;

    // Hold the pointer: reset, software byte writes, then the arithmetic step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= PTR_W'(TOP_ADDR);
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) sp_q[7:0]       <= wdata;
            if (wr_hi) sp_q[PTR_W-1:8] <= wdata[HI_W-1:0];
        end else if (step != STEP_NONE) begin
            sp_q <= sp_next;
        end
    end

    assign sp    = sp_q;
    assign rd_lo = sp_q[7:0];
    assign rd_hi = {{(16-PTR_W){1'b0}}, sp_q[PTR_W-1:8]};
endmodule

// File: rtl/stk_ptr_unit.sv
// Top of the downward stack pointer unit: sequencer, address generator and
// byte-accessible pointer register. Memory array and command decode are
// outside. Commands are expected one at a time; priority resolves overlaps.
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int PTR_W    = 11,
    parameter int TOP_ADDR = 11'h7FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_push,
    input  logic             cmd_pop,
    input  logic             cmd_call,
    input  logic             cmd_ret,
    input  logic             sw_wr_lo,
    input  logic             sw_wr_hi,
    input  logic [7:0]       sw_wdata,
    output logic [7:0]       sw_rdata_lo,
    output logic [7:0]       sw_rdata_hi,
    output logic [PTR_W-1:0] sp_q,
    output logic [PTR_W-1:0] mem_addr,
    output logic             mem_valid,
    output logic             mem_wr,
    output logic             mem_hi_byte
);
    step_t            step_w;
    logic             busy_w;
    logic [PTR_W-1:0] sp_next_w;

    stk_cmd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_push   (cmd_push),
        .cmd_pop    (cmd_pop),
        .cmd_call   (cmd_call),
        .cmd_ret    (cmd_ret),
        .sw_wr      (sw_wr_lo | sw_wr_hi),
        .step       (step_w),
        .mem_valid  (mem_valid),
        .mem_wr     (mem_wr),
        .mem_hi_byte(mem_hi_byte),
        .busy       (busy_w)
    );

    stk_addr_gen #(.PTR_W(PTR_W)) u_addr (
        .sp     (sp_q),
        .step   (step_w),
        .addr   (mem_addr),
        .sp_next(sp_next_w)
    );

    stk_ptr_reg #(.PTR_W(PTR_W), .TOP_ADDR(TOP_ADDR)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (sw_wr_lo),
        .wr_hi  (sw_wr_hi),
        .wdata  (sw_wdata),
        .step   (step_w),
        .sp_next(sp_next_w),
        .sp     (sp_q),
        .rd_lo  (sw_rdata_lo),
        .rd_hi  (sw_rdata_hi)
    );
endmodule

// File: rtl/stk_ptr_chk.sv
// Property checker for stk_ptr_unit, attached by bind below.
module stk_ptr_chk #(
    parameter int PTR_W    = 11,
    parameter int TOP_ADDR = 11'h7FF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_push,
    input logic             cmd_pop,
    input logic             cmd_call,
    input logic             cmd_ret,
    input logic             sw_wr_lo,
    input logic             sw_wr_hi,
    input logic [7:0]       sw_wdata,
    input logic [7:0]       sw_rdata_hi,
    input logic [PTR_W-1:0] sp_q,
    input logic [PTR_W-1:0] mem_addr,
    input logic             mem_valid,
    input logic             mem_wr,
    input logic             busy
);
    localparam int HI_W = PTR_W - 8;

    logic sw_any;
    assign sw_any = sw_wr_lo | sw_wr_hi;

    AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> sp_q == PTR_W'(TOP_ADDR)); // R1

    AST_PUSH_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_push && !sw_any) |=> sp_q == PTR_W'($past(sp_q) - PTR_W'(1))); // R2

    AST_POP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_pop && !cmd_push && !sw_any) |=> sp_q == PTR_W'($past(sp_q) + PTR_W'(1))); // R3

    AST_CALL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_call && !cmd_push && !cmd_pop && !sw_any)
        |=> busy && mem_wr && mem_addr == PTR_W'($past(sp_q) - PTR_W'(1))); // R4

    AST_RET_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_ret && !cmd_call && !cmd_push && !cmd_pop && !sw_any)
        |=> busy && !mem_wr && mem_addr == PTR_W'($past(sp_q) + PTR_W'(2))); // R5

    AST_BUSY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R6

    AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata_hi >> HI_W) == 8'd0); // R7

    AST_SW_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_lo |=> sp_q[7:0] == $past(sw_wdata)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_push && !cmd_pop && !cmd_call && !cmd_ret) |-> !mem_valid); // R10
endmodule

bind stk_ptr_unit stk_ptr_chk #(.PTR_W(PTR_W), .TOP_ADDR(TOP_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_push   (cmd_push),
    .cmd_pop    (cmd_pop),
    .cmd_call   (cmd_call),
    .cmd_ret    (cmd_ret),
    .sw_wr_lo   (sw_wr_lo),
    .sw_wr_hi   (sw_wr_hi),
    .sw_wdata   (sw_wdata),
    .sw_rdata_hi(sw_rdata_hi),
    .sp_q       (sp_q),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_wr     (mem_wr),
    .busy       (busy_w)
);

// File: tb/sim_stk_ptr_unit.sv
// Bench: behavioural reference model compared with the design every cycle.
module sim_stk_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push = 1'b0, cmd_pop = 1'b0, cmd_call = 1'b0, cmd_ret = 1'b0;
    logic        sw_wr_lo = 1'b0, sw_wr_hi = 1'b0;
    logic [7:0]  sw_wdata = 8'h00;
    logic [7:0]  sw_rdata_lo, sw_rdata_hi;
    logic [10:0] sp_q, mem_addr;
    logic        mem_valid, mem_wr, mem_hi_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model state
    int m_sp   = 0;
    int m_busy = 0;
    int m_call = 0;

    always #10 clk = ~clk;   // 50 MHz

    stk_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
        .sw_wr_lo(sw_wr_lo), .sw_wr_hi(sw_wr_hi), .sw_wdata(sw_wdata),
        .sw_rdata_lo(sw_rdata_lo), .sw_rdata_hi(sw_rdata_hi), .sp_q(sp_q),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_hi_byte(mem_hi_byte)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, clock, update the model.
    task automatic cyc(input string tag, input bit p, input bit o, input bit c, input bit r,
                       input bit wl, input bit wh, input logic [7:0] wd);
        int e_valid = 0, e_wr = 0, e_hi = 0, e_addr = 0, e_step = 0, e_start = 0;
        cmd_push = p; cmd_pop = o; cmd_call = c; cmd_ret = r;
        sw_wr_lo = wl; sw_wr_hi = wh; sw_wdata = wd;
        #2;
        if (m_busy != 0) begin
            e_valid = 1; e_wr = m_call; e_hi = m_call;
            e_step = m_call ? -1 : 1;
        end else if (p) begin
            e_valid = 1; e_wr = 1; e_step = -1;
        end else if (o) begin
            e_valid = 1; e_step = 1;
        end else if (c) begin
            e_valid = 1; e_wr = 1; e_step = -1; e_start = 1;
        end else if (r) begin
            e_valid = 1; e_hi = 1; e_step = 1; e_start = 2;
        end
        e_addr = (e_step == 1) ? ((m_sp + 1) % 2048) : m_sp;
        check(tag, "rd_lo", int'(sw_rdata_lo), m_sp % 256);
        check(tag, "rd_hi", int'(sw_rdata_hi), m_sp / 256);
        check(tag, "sp", int'(sp_q), m_sp);
        check(tag, "valid", int'(mem_valid), e_valid);
        if (e_valid != 0) begin
            check(tag, "addr", int'(mem_addr), e_addr);
            check(tag, "wr", int'(mem_wr), e_wr);
            check(tag, "hi_byte", int'(mem_hi_byte), e_hi);
        end
        @(posedge clk);
        if (wl || wh) begin
            if (wl) m_sp = (m_sp / 256) * 256 + int'(wd);
            if (wh) m_sp = (int'(wd) % 8) * 256 + (m_sp % 256);
            m_busy = 0;
        end else begin
            m_sp   = (m_sp + e_step + 2048) % 2048;
            m_busy = (e_start != 0) ? 1 : 0;
            if (e_start != 0) m_call = (e_start == 1) ? 1 : 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_sp  = 2047;
        // R1: reset value visible through both byte registers
        idle("R1");
        // R2: pushes
        cyc("R2", 1, 0, 0, 0, 0, 0, 8'h00);
        cyc("R2", 1, 0, 0, 0, 0, 0, 8'h00);
        // R3: pops
        cyc("R3", 0, 1, 0, 0, 0, 0, 8'h00);
        cyc("R3", 0, 1, 0, 0, 0, 0, 8'h00);
        // R4: call, two cycles
        cyc("R4", 0, 0, 1, 0, 0, 0, 8'h00);
        idle("R4");
        idle("R4");
        // R5: return, two cycles
        cyc("R5", 0, 0, 0, 1, 0, 0, 8'h00);
        idle("R5");
        idle("R5");
        // R6: strobes during second cycle are dropped
        cyc("R6", 0, 0, 1, 0, 0, 0, 8'h00);
        cyc("R6", 1, 1, 1, 1, 0, 0, 8'h00);
        idle("R6");
        cyc("R6", 0, 0, 0, 1, 0, 0, 8'h00);
        cyc("R6", 1, 0, 0, 0, 0, 0, 8'h00);
        idle("R6");
        // R7: high byte upper bits read zero and ignore writes
        cyc("R7", 0, 0, 0, 0, 0, 1, 8'hFD);
        idle("R7");
        cyc("R7", 0, 0, 0, 0, 1, 0, 8'h3C);
        idle("R7");
        // R8: software write beats a push, and cancels a pending call cycle
        cyc("R8", 1, 0, 0, 0, 1, 0, 8'h80);
        idle("R8");
        cyc("R8", 0, 0, 1, 0, 0, 0, 8'h00);
        cyc("R8", 0, 0, 0, 0, 0, 1, 8'h02);
        idle("R8");
        cyc("R8", 0, 1, 0, 0, 1, 1, 8'h11);
        idle("R8");
        // R9: wrap at zero and at the top
        cyc("R9", 0, 0, 0, 0, 1, 1, 8'h00);
        cyc("R9", 1, 0, 0, 0, 0, 0, 8'h00);
        cyc("R9", 0, 1, 0, 0, 0, 0, 8'h00);
        cyc("R9", 0, 0, 1, 0, 1, 1, 8'h00);
        idle("R9");
        cyc("R9", 0, 0, 0, 1, 0, 0, 8'h00);
        cyc("R9", 0, 0, 0, 0, 1, 1, 8'h07);
        cyc("R9", 0, 0, 0, 0, 1, 0, 8'hFF);
        cyc("R9", 0, 0, 0, 1, 0, 0, 8'h00);
        idle("R9");
        // R10: idle and overlapping strobes
        idle("R10");
        cyc("R10", 1, 1, 1, 1, 0, 0, 8'h00);
        cyc("R10", 0, 1, 1, 1, 0, 0, 8'h00);
        cyc("R10", 0, 0, 1, 1, 0, 0, 8'h00);
        idle("R10");
        // Mixed pseudo-random phase
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc("R10", lfsr[0] & lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5] & lfsr[6],
                    lfsr[7] & lfsr[8] & lfsr[9], lfsr[10] & lfsr[11] & lfsr[12],
                    lfsr[13] & lfsr[14] & lfsr[15], lfsr[15:8]);
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule